// File: doc/BRIEF.md
# I2C Bit-Rate Clock Generator

This block turns a fast system clock into the timing strobe that an I2C master's bit engine uses to step SCL. The block divides the clock in two stages. First, a power-of-two prescaler divides by 32, 16, 8 or 4. Second, an offset divider counts prescaler ticks up to an 8-bit divider value plus three. When the filter option is set, it adds two more ticks to that count. The block pulses `half_tick` at every SCL half-period edge. The whole SCL period is therefore twice the half period.

Software programs the block through a small write port that reaches two registers: a mode register and a divider register. The block applies only the values that software programs. It does not choose a divider setting. A new setting does not change a half period that is already running. The block loads it at the next full-period boundary, so SCL never sees a shortened phase.

Top module: `bit_rate_gen`

## Requirements
- R1: After reset, the mode register reads as all zero, so the block is disabled, and `half_tick` stays low.
- R2: A write with `reg_sel`=0 loads the mode register from `reg_wdata[3:0]`: bit 0 is enable, bits 2:1 are the prescaler select and bit 3 is the filter option. A write with `reg_sel`=1 loads the 8-bit divider value from `reg_wdata`.
- R3: Prescaler select values 0, 1, 2 and 3 divide the system clock by 32, 16 and 8 and 4 respectively.
- R4: One half period lasts P×(D+3+2×F) system clocks, where P is the prescaler ratio, D is the divider value and F is the filter bit. A full SCL period is twice that.
- R5: `half_tick` is high for exactly one system clock per half period.
- R6: While enable is 0, every counter is held cleared and `half_tick` stays low. After a write sets enable, the first pulse comes exactly one half period later, counted from the clock edge that captured the write.
- R7: A setting written while the block runs takes effect only at the next full-period boundary. The half period already in progress keeps the old length.
- R8: A write captured on the same clock edge as a full-period boundary does not affect the next full period. It takes effect at the boundary after that.
- R9: Every divider value from 0 to 255 is honoured, with both filter settings and all four prescaler ratios.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 mode register, 1 divider register |
| reg_wdata | input | 8 | Write data |
| half_tick | output | 1 | One-clock pulse at each SCL half-period edge |

## Verification
Two events can fall on the same clock edge: a register write and the full-period boundary at which the shadow settings reload. The bench provokes this by waiting until it sees the second pulse after enable, then driving a new divider value in that same low clock phase. The write is then captured on the boundary edge. The bench judges the result by the pulse spacing: the next two gaps must keep the old length, and only the gap after that may use the new value. A second case places the write on the first pulse instead. That write lands mid-period, so the new value must appear one half period sooner.

// File: rtl/brg_pkg.sv
package brg_pkg;
    localparam int DIV_W    = 8;
    localparam int SEL_W    = 2;
    localparam int PRE_LOG2 = 5;
    localparam int HALF_W   = DIV_W + 1;
    localparam int GAP_W    = PRE_LOG2 + HALF_W + 2;

    typedef struct packed {
        logic             filt;
        logic [SEL_W-1:0] sel;
        logic             en;
    } mode_t;

    typedef struct packed {
        logic             filt;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
    } rate_t;
endpackage

// File: rtl/brg_cfg_regs.sv
module brg_cfg_regs
    import brg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [DIV_W-1:0] wdata,
    input  logic             boundary,
    output logic             en,
    output rate_t            act
);
    typedef struct packed {
        mode_t            mode;
        logic [DIV_W-1:0] div;
        rate_t            act;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (sel) st_d.div  = wdata;
            else     st_d.mode = mode_t'(wdata[3:0]);
        end
        if (!st_q.mode.en || boundary) begin
            st_d.act.filt = st_q.mode.filt;
            st_d.act.sel  = st_q.mode.sel;
            st_d.act.div  = st_q.div;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en  = st_q.mode.en;
    assign act = st_q.act;
endmodule

// File: rtl/brg_prescale.sv
module brg_prescale
    import brg_pkg::*;
#(
    parameter int LOG2_MAX = PRE_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam logic [LOG2_MAX-1:0] TOP_M1 = '1;

    typedef struct packed {
        logic [LOG2_MAX-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [LOG2_MAX-1:0] lim;
    logic                wrap;

    always_comb begin
        lim  = TOP_M1 >> sel;
        wrap = (st_q.cnt == lim);
        st_d = st_q;
        if (!en)       st_d.cnt = '0;
        else if (wrap) st_d.cnt = '0;
        else           st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = en && wrap;
endmodule

// File: rtl/brg_halfcount.sv
module brg_halfcount
    import brg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    input  logic             filt,
    output logic             strobe,
    output logic             phase
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              phase;
    } half_state_t;

    half_state_t st_d, st_q;
    logic [HALF_W-1:0] lim_m1;
    logic              last;

    always_comb begin
        lim_m1 = HALF_W'(div) + HALF_W'(2) + (filt ? HALF_W'(2) : HALF_W'(0));
        last   = (st_q.cnt == lim_m1);
        st_d   = st_q;
        if (!en) begin
            st_d = '0;
        end else if (tick) begin
            if (last) begin
                st_d.cnt   = '0;
                st_d.phase = ~st_q.phase;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = tick && last;
    assign phase  = st_q.phase;
endmodule

// File: rtl/bit_rate_gen.sv
module bit_rate_gen
    import brg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [DIV_W-1:0] reg_wdata,
    output logic             half_tick
);
    logic  en_w;
    rate_t act_w;
    logic  pre_tick;
    logic  phase_w;
    logic  boundary_w;

    assign boundary_w = half_tick && phase_w;

    brg_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .boundary (boundary_w),
        .en       (en_w),
        .act      (act_w)
    );

    brg_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_w),
        .sel   (act_w.sel),
        .tick  (pre_tick)
    );

    brg_halfcount u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_w),
        .tick   (pre_tick),
        .div    (act_w.div),
        .filt   (act_w.filt),
        .strobe (half_tick),
        .phase  (phase_w)
    );
endmodule

// File: rtl/brg_checker.sv
module brg_checker
    import brg_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  en,
    input logic  strobe,
    input logic  phase,
    input rate_t act
);
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] half_len;

    always_comb begin
        half_len = (GAP_W'(1) << (PRE_LOG2 - int'(act.sel)))
                 * (GAP_W'(act.div) + GAP_W'(3) + (act.filt ? GAP_W'(2) : GAP_W'(0)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               gap_q <= '0;
        else if (!en || strobe)   gap_q <= '0;
        else                      gap_q <= gap_q + 1'b1;
    end

    // R5: a pulse never lasts two clocks
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R6: silent while disabled
    assert_quiet_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !strobe);

    // R4: spacing matches the active setting
    assert_half_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (gap_q + 1'b1 == half_len));

    // R7: active setting frozen between full-period boundaries
    assert_hold_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !(strobe && phase)) |=> $stable(act));

    // R4: each pulse flips the half-period phase
    assert_phase_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && strobe) |=> (phase != $past(phase)));
endmodule

bind bit_rate_gen brg_checker u_brg_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en_w),
    .strobe (half_tick),
    .phase  (phase_w),
    .act    (act_w)
);

// File: tb/bit_rate_gen_bench.sv
module bit_rate_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct packed {
        logic [1:0]  sel;
        logic        filt;
        logic [7:0]  div;
        logic [15:0] half;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 1'b0, 8'd0,   16'd96},   '{2'd0, 1'b1, 8'd0,   16'd160},
        '{2'd0, 1'b0, 8'd1,   16'd128},  '{2'd0, 1'b1, 8'd1,   16'd192},
        '{2'd0, 1'b0, 8'd255, 16'd8256}, '{2'd0, 1'b1, 8'd255, 16'd8320},
        '{2'd1, 1'b0, 8'd0,   16'd48},   '{2'd1, 1'b1, 8'd0,   16'd80},
        '{2'd1, 1'b0, 8'd1,   16'd64},   '{2'd1, 1'b1, 8'd1,   16'd96},
        '{2'd1, 1'b0, 8'd255, 16'd4128}, '{2'd1, 1'b1, 8'd255, 16'd4160},
        '{2'd2, 1'b0, 8'd0,   16'd24},   '{2'd2, 1'b1, 8'd0,   16'd40},
        '{2'd2, 1'b0, 8'd1,   16'd32},   '{2'd2, 1'b1, 8'd1,   16'd48},
        '{2'd2, 1'b0, 8'd255, 16'd2064}, '{2'd2, 1'b1, 8'd255, 16'd2080},
        '{2'd3, 1'b0, 8'd0,   16'd12},   '{2'd3, 1'b1, 8'd0,   16'd20},
        '{2'd3, 1'b0, 8'd1,   16'd16},   '{2'd3, 1'b1, 8'd1,   16'd24},
        '{2'd3, 1'b0, 8'd255, 16'd1032}, '{2'd3, 1'b1, 8'd255, 16'd1040}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       half_tick;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    bit_rate_gen u_bit_rate_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .half_tick (half_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [7:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // drive a write now, captured at the coming edge; next gap measure clears it
    task automatic post_write(input logic sel, input logic [7:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    endtask

    // called right after the enabling write returns
    task automatic first_latency(output int n);
        n = 1;
        while (!half_tick && n < 20000) begin
            @(negedge clk); reg_wr = 1'b0; n++;
        end
    endtask

    task automatic next_gap(output int n);
        n = 0;
        do begin
            @(negedge clk); reg_wr = 1'b0; n++;
        end while (!half_tick && n < 20000);
    endtask

    task automatic start(input logic [1:0] sel, input logic filt, input logic [7:0] div);
        reg_write(1'b0, {4'd0, filt, sel, 1'b0});
        reg_write(1'b1, div);
        reg_write(1'b0, {4'd0, filt, sel, 1'b1});
    endtask

    initial begin
        int n;
        int highs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        highs = 0;
        repeat (50) begin @(negedge clk); if (half_tick) highs++; end
        check("R1 idle after reset", highs, 0);

        // R2 R3 R4 R9: every prescaler, divider 0/1/255, filter off and on
        for (int i = 0; i < NVEC; i++) begin
            start(VEC[i].sel, VEC[i].filt, VEC[i].div);
            first_latency(n);
            check($sformatf("R6 first pulse vec%0d", i), n, int'(VEC[i].half));
            next_gap(n);
            check($sformatf("R3 R4 R9 gap vec%0d", i), n, int'(VEC[i].half));
        end

        // R7: write mid-period (on first pulse) -> new value one half period later
        start(2'd3, 1'b0, 8'd0);
        first_latency(n);
        check("R7 latency", n, 12);
        post_write(1'b1, 8'd1);
        next_gap(n); check("R7 old half kept", n, 12);
        next_gap(n); check("R7 new value", n, 16);
        next_gap(n); check("R7 new value held", n, 16);

        // R8: write captured on the boundary edge -> applies one full period later
        start(2'd3, 1'b0, 8'd0);
        first_latency(n);
        next_gap(n); check("R8 second pulse", n, 12);
        post_write(1'b1, 8'd1);
        next_gap(n); check("R8 old period first half", n, 12);
        next_gap(n); check("R8 old period second half", n, 12);
        next_gap(n); check("R8 new value", n, 16);

        // R6: disable mid-run, silence, then restart from cleared counters
        start(2'd3, 1'b0, 8'd0);
        first_latency(n);
        reg_write(1'b0, 8'h06);
        highs = 0;
        repeat (40) begin @(negedge clk); if (half_tick) highs++; end
        check("R6 silent when disabled", highs, 0);
        reg_write(1'b0, 8'h07);
        first_latency(n);
        check("R6 restart latency", n, 12);
        @(negedge clk);
        check("R5 pulse one clock", int'(half_tick), 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule